// File: doc/BRIEF.md
# Bit-Counting I2C Shift Engine

This block moves one byte at a time over an I2C bus under processor control. The processor reaches it through a small register port with three addresses: data, control and status. The block shifts bits out of its 8-bit data register and samples bits into it as the bus clock toggles. It counts falling clock edges. It raises a bit-count flag when a byte, or a single acknowledge bit, has gone by. Optionally it holds the bus clock low until software has dealt with that flag. A second flag reports START and STOP conditions seen on the bus.

Software does everything that needs protocol knowledge: clock generation, addressing, and creating START and STOP. Acknowledges are software writes of a special byte. Writing 0x7F pulls SDA low for the acknowledge slot. Writing 0xFF leaves SDA released, either for a NACK or so a transmitter can sample the receiver's answer. Both bus outputs are active-low open-drain enables.

Top module: `i2c_shift_engine`

## Requirements
- R1: After reset, both open-drain enables are 1 (lines released), the status register reads 0x00, and both interrupt outputs are 0.
- R2: Each falling edge of the synchronized SCL adds one to the bit count, which reads back in status bits [7:4].
- R3: A read or write of the data register (address 0) clears the bit count, and so does a START or STOP condition on the bus.
- R4: With control bit 1 at 0 (byte mode), the bit-count flag (status bit 2) sets on the falling edge that brings the count to 8. `irq_cnt` follows it when control bit 2 is 1.
- R5: With control bit 1 at 1 (single-bit mode), the bit-count flag sets on the falling edge that brings the count to 1.
- R6: While the bit-count flag is set, control bit 0 (stretch) is 1 and control bit 1 is 0, `scl_oe_n` is 0. Setting control bit 1, or writing the data register, releases SCL.
- R7: SDA is sampled on each rising SCL edge into the data register, shifting toward the MSB, so after eight bits a data read returns the received byte with the first bit as bit 7.
- R8: Writing the data register drives bit 7 at once. Each following falling SCL edge presents the next lower bit. From the falling edge that brings the count to 8 onward, SDA is released.
- R9: Writing 0x7F pulls SDA low for the next clock, and it is released after that clock's falling edge. Writing 0xFF leaves SDA released.
- R10: A data read or write clears the bit-count flag. If the flag is still set when the next falling edge moves the count past the threshold, the flag drops.
- R11: SDA falling while SCL is high sets the START flag (status bit 0). SDA rising while SCL is high sets the STOP flag (status bit 1). `irq_ss` is their OR gated by control bit 3.
- R12: Writing status with a 1 in bit 0, 1 or 2 clears that flag. Zeros leave the flags as they are, and the count is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_oe_n | output | 1 | SCL pull-down enable, 0 drives low |
| sda_oe_n | output | 1 | SDA pull-down enable, 0 drives low |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_cnt | output | 1 | Bit-count interrupt |
| irq_ss | output | 1 | START/STOP interrupt |

## Verification
A change on a bus pin reaches the engine's state on the third rising clock edge: two synchronizer flops, then the state register. Counts, flags, the shifted byte and SDA therefore move three cycles after the bus line. Register writes take effect at the first rising edge, and `scl_oe_n` follows in the same cycle through combinational logic. The bench holds every bus level for four clock cycles and samples only on falling clock edges after that wait, so each check reads a settled value.

// File: rtl/i2c_se_pkg.sv
package i2c_se_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic ss_ie;       // bit 3
        logic cnt_ie;      // bit 2
        logic one_bit;     // bit 1
        logic stretch_en;  // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              sda_rel;
        logic              cnt_f;
        logic              start_f;
        logic              stop_f;
        ctrl_t             ctrl;
    } eng_t;
endpackage

// File: rtl/i2c_se_sync.sv
module i2c_se_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    // stages 0..STAGES-1 synchronize, stage STAGES keeps the previous level
    logic [STAGES:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= {stg_q[STAGES-1:0], din};
    end

    assign lvl  = stg_q[STAGES-1];
    assign prev = stg_q[STAGES];
endmodule

// File: rtl/i2c_se_cond.sv
module i2c_se_cond (
    input  logic scl_lvl,
    input  logic scl_prev,
    input  logic sda_lvl,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_steady_hi;

    assign scl_steady_hi = scl_lvl & scl_prev;
    assign scl_rise      = scl_lvl & ~scl_prev;
    assign scl_fall      = ~scl_lvl & scl_prev;
    assign start_det     = scl_steady_hi & sda_prev & ~sda_lvl;
    assign stop_det      = scl_steady_hi & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_shift_engine.sv
module i2c_shift_engine
    import i2c_se_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_n,
    output logic              sda_oe_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_cnt,
    output logic              irq_ss
);
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    eng_t st_d, st_q;

    logic [1:0] bus_lvl, bus_prev;
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic data_wr, data_rd, data_acc, ctrl_wr, stat_wr;
    logic [CNT_W-1:0] thr, cnt_inc;

    i2c_se_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .lvl  (bus_lvl),
        .prev (bus_prev)
    );

    assign {scl_s, sda_s} = bus_lvl;
    assign {scl_p, sda_p} = bus_prev;

    i2c_se_cond u_cond (
        .scl_lvl  (scl_s),
        .scl_prev (scl_p),
        .sda_lvl  (sda_s),
        .sda_prev (sda_p),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign data_wr  = reg_wr && (reg_addr == ADDR_DATA);
    assign data_rd  = reg_rd && (reg_addr == ADDR_DATA);
    assign data_acc = data_wr | data_rd;
    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr  = reg_wr && (reg_addr == ADDR_STAT);
    assign thr      = st_q.ctrl.one_bit ? CNT_ONE : CNT_BYTE;
    assign cnt_inc  = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + CNT_ONE;

    always_comb begin
        st_d = st_q;
        // software clear of flags first, so a same-cycle event wins
        if (stat_wr) begin
            if (reg_wdata[0]) st_d.start_f = 1'b0;
            if (reg_wdata[1]) st_d.stop_f  = 1'b0;
            if (reg_wdata[2]) st_d.cnt_f   = 1'b0;
        end
        if (ctrl_wr) st_d.ctrl = ctrl_t'(reg_wdata[3:0]);
        if (scl_rise) st_d.sr = {st_q.sr[BYTE_W-2:0], sda_s};
        if (scl_fall) begin
            st_d.cnt     = cnt_inc;
            st_d.cnt_f   = (cnt_inc == thr);
            st_d.sda_rel = (cnt_inc >= CNT_BYTE) | st_q.sr[BYTE_W-1];
        end
        if (start_det | stop_det) st_d.cnt = '0;
        if (start_det) st_d.start_f = 1'b1;
        if (stop_det)  st_d.stop_f  = 1'b1;
        if (data_acc) begin
            st_d.cnt   = '0;
            st_d.cnt_f = 1'b0;
        end
        if (data_wr) begin
            st_d.sr      = reg_wdata;
            st_d.sda_rel = reg_wdata[BYTE_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.sr      <= '1;
            st_q.sda_rel <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_n = st_q.sda_rel;
    assign scl_oe_n = ~(st_q.ctrl.stretch_en & st_q.cnt_f & ~st_q.ctrl.one_bit);
    assign irq_cnt  = st_q.cnt_f & st_q.ctrl.cnt_ie;
    assign irq_ss   = (st_q.start_f | st_q.stop_f) & st_q.ctrl.ss_ie;

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = st_q.sr;
            ADDR_CTRL: reg_rdata = {{(BYTE_W-4){1'b0}}, st_q.ctrl};
            ADDR_STAT: reg_rdata = {st_q.cnt, 1'b0, st_q.cnt_f, st_q.stop_f, st_q.start_f};
            default:   reg_rdata = '0;
        endcase
    end

    // SDA may only move on a write or after a falling SCL edge
    p_sda_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_p && !data_wr) |=> $stable(sda_oe_n));

    // any data access leaves the count at zero
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> (st_q.cnt == '0));

    // the bit-count flag only rises after a falling SCL edge
    p_flag_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cnt_f) |-> $past(scl_fall));

    // START flag only rises while SCL was high
    p_start_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.start_f) |-> $past(scl_s && scl_p));

    // a data write always releases a stretched clock
    p_stretch_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> scl_oe_n);
endmodule

// File: tb/i2c_shift_engine_tb.sv
module i2c_shift_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_tb = 1'b1, sda_tb = 1'b1;
    logic scl_oe_n, sda_oe_n, irq_cnt, irq_ss;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic scl_bus, sda_bus;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign scl_bus = scl_tb & scl_oe_n;
    assign sda_bus = sda_tb & sda_oe_n;

    i2c_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_cnt(irq_cnt), .irq_ss(irq_ss)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_cyc(1);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = (a == 2'd0);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        wait_cyc(1);
    endtask

    task automatic bus_bit(input logic b);
        sda_tb = b;  wait_cyc(4);
        scl_tb = 1'b1; wait_cyc(4);
        scl_tb = 1'b0; wait_cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "sda_oe_n", {7'd0, sda_oe_n}, 8'h01);
        chk("R1", "scl_oe_n", {7'd0, scl_oe_n}, 8'h01);
        chk("R1", "irqs", {6'd0, irq_cnt, irq_ss}, 8'h00);
        rd(2'd2, v);
        chk("R1", "status", v, 8'h00);
    endtask

    task automatic t_start();
        logic [7:0] v;
        wr(2'd1, 8'h08);
        sda_tb = 1'b0; wait_cyc(4);
        rd(2'd2, v);
        chk("R11", "start flag", v, 8'h01);
        chk("R11", "irq_ss", {7'd0, irq_ss}, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, v);
        chk("R12", "zero write keeps flag", v, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, v);
        chk("R12", "w1c start", v, 8'h00);
        scl_tb = 1'b0; wait_cyc(4);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        logic [7:0] rx = 8'hA5;
        wr(2'd1, 8'h04);
        wr(2'd0, 8'hFF);
        for (int i = 7; i >= 1; i--) bus_bit(rx[i]);
        rd(2'd2, v);
        chk("R2", "count after 7", v, 8'h70);
        bus_bit(rx[0]);
        rd(2'd2, v);
        chk("R4", "flag at 8", v, 8'h84);
        chk("R4", "irq_cnt", {7'd0, irq_cnt}, 8'h01);
        chk("R8", "sda released at 8", {7'd0, sda_oe_n}, 8'h01);
        rd(2'd0, v);
        chk("R7", "received byte", v, 8'hA5);
        rd(2'd2, v);
        chk("R10", "read clears flag and count (R3)", v, 8'h00);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        wr(2'd0, 8'h7F);
        chk("R9", "ack drives low", {7'd0, sda_oe_n}, 8'h00);
        sda_tb = 1'b1; wait_cyc(4);
        scl_tb = 1'b1; wait_cyc(4);
        chk("R9", "ack bus low", {7'd0, sda_bus}, 8'h00);
        scl_tb = 1'b0; wait_cyc(4);
        chk("R9", "ack released", {7'd0, sda_oe_n}, 8'h01);
        rd(2'd2, v);
        chk("R2", "count after ack", v, 8'h10);
        wr(2'd0, 8'hFF);
        chk("R9", "nack stays released", {7'd0, sda_oe_n}, 8'h01);
    endtask

    task automatic t_transmit();
        logic [7:0] tx = 8'h3C;
        wr(2'd0, tx);
        for (int i = 7; i >= 0; i--) begin
            chk("R8", "tx bit", {7'd0, sda_oe_n}, {7'd0, tx[i]});
            bus_bit(1'b1);
        end
        chk("R8", "tx released", {7'd0, sda_oe_n}, 8'h01);
    endtask

    task automatic t_stretch();
        logic [7:0] v;
        wr(2'd1, 8'h05);
        wr(2'd0, 8'hFF);
        for (int i = 0; i < 8; i++) bus_bit(1'b1);
        chk("R6", "stretch held", {7'd0, scl_oe_n}, 8'h00);
        wr(2'd1, 8'h07);
        chk("R6", "one-bit select releases", {7'd0, scl_oe_n}, 8'h01);
        wr(2'd2, 8'h04);
        rd(2'd2, v);
        chk("R12", "w1c cnt flag keeps count", v, 8'h80);
        wr(2'd1, 8'h05);
        wr(2'd0, 8'hFF);
        for (int i = 0; i < 8; i++) bus_bit(1'b1);
        chk("R6", "stretch again", {7'd0, scl_oe_n}, 8'h00);
        wr(2'd0, 8'hFF);
        chk("R6", "data write releases", {7'd0, scl_oe_n}, 8'h01);
        rd(2'd2, v);
        chk("R10", "write clears flag", v, 8'h00);
    endtask

    task automatic t_one_bit();
        logic [7:0] v;
        wr(2'd1, 8'h06);
        wr(2'd0, 8'hFF);
        bus_bit(1'b1);
        rd(2'd2, v);
        chk("R5", "flag after one bit", v, 8'h14);
        bus_bit(1'b1);
        rd(2'd2, v);
        chk("R10", "unread flag dropped", v, 8'h20);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        sda_tb = 1'b0; wait_cyc(4);
        scl_tb = 1'b1; wait_cyc(4);
        sda_tb = 1'b1; wait_cyc(4);
        rd(2'd2, v);
        chk("R11", "stop flag, count cleared (R3)", v, 8'h02);
        chk("R11", "irq_ss gated off", {7'd0, irq_ss}, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_start();
        t_receive();
        t_ack();
        t_transmit();
        t_stretch();
        t_one_bit();
        t_stop();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule